// File: doc/BRIEF.md
# Multi-sequence index register file

The block stores 64 signed 18-bit index registers and also keeps track of which hardware sequence is active. Each sequence keeps its program counter in the index register whose number equals the sequence number. Register 0 is the toggle start point, and by the same rule it is also the program counter of sequence 0. A single clocked port reads and writes registers by a 6-bit register number. The write side can load a value, or it can increment or decrement the stored value with 18-bit wraparound.

Control logic changes the active sequence in one of two ways. It can issue a sequence-change request that carries the new number. Or, while no sequence has been valid since reset, it can issue a start command, which selects sequence 0. Each change sets a guard flip-flop. While the guard is set, a read of the active program-counter register (other than register 0) returns zero in place of the stored value. The stored value is left intact. The first read of that register that is marked as a program-fetch reference clears the guard.

The block also holds a runnable flag for each sequence and reports the flag of the active sequence. It keeps a single bit that records whether the last completed instruction carried its hold bit.

Top module: `seq_index_regfile`

## Requirements
- R1: After synchronous reset, every register holds 0. `rd_data`, `cur_valid`, `guard`, `cur_runnable` and `prev_hold` are all 0.
- R2: A read with `rd_en` high presents data on `rd_data` after the next rising edge. While `rd_en` is low, `rd_data` keeps its value.
- R3: With `wr_en` high and `wr_op` 0 or 3, the register at `wr_addr` is loaded with `wr_data`. A read of the same address in the same cycle returns the value from before the write.
- R4: `wr_op` 1 adds one and `wr_op` 2 subtracts one from the stored register, modulo 2^18. So 0x1FFFF+1 gives 0x20000, 0x3FFFF+1 gives 0, and 0-1 gives 0x3FFFF.
- R5: `start` while `cur_valid` is 0 makes sequence 0 current, sets `cur_valid` and sets `guard`. While `cur_valid` is 1, `start` has no effect.
- R6: `seq_change` loads `seq_new` into `cur_seq`, sets `cur_valid` and sets `guard` on the next edge. It takes priority over `start` in the same cycle.
- R7: A read of register `cur_seq` returns 0 if all of these hold: the register is not 0, `cur_valid` is 1, and `guard` is 1. The stored value is unchanged, and reads of other registers are unaffected.
- R8: A read of register 0 always returns its stored value, even when sequence 0 is current and `guard` is set.
- R9: A read of register `cur_seq` with `fetch_cycle` high clears `guard` from the next cycle. A read without `fetch_cycle` leaves `guard` set.
- R10: If `seq_change` and a guard-clearing read occur in the same cycle, `guard` stays set and the new sequence number is loaded.
- R11: `flag_we` writes `flag_val` into the runnable flag of sequence `flag_seq`. `cur_runnable` equals the flag of `cur_seq` while `cur_valid` is 1, and is 0 otherwise. A change is visible the cycle after the write.
- R12: When `insn_done` is high, `prev_hold` takes the value of `insn_hold` on the next edge. Otherwise `prev_hold` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request |
| rd_addr | input | 6 | Register number to read |
| fetch_cycle | input | 1 | Marks the read as a program-fetch reference |
| rd_data | output | 18 | Registered read result |
| wr_en | input | 1 | Write request |
| wr_op | input | 2 | Write operation: 0 load, 1 increment, 2 decrement, 3 load |
| wr_addr | input | 6 | Register number to write |
| wr_data | input | 18 | Load value |
| seq_change | input | 1 | Sequence-change request |
| seq_new | input | 6 | Number of the new sequence |
| start | input | 1 | Start command from the initial state |
| cur_seq | output | 6 | Current sequence number |
| cur_valid | output | 1 | A sequence has been selected |
| guard | output | 1 | Read-guard flip-flop |
| flag_we | input | 1 | Runnable flag write |
| flag_seq | input | 6 | Sequence whose flag is written |
| flag_val | input | 1 | New flag value |
| cur_runnable | output | 1 | Runnable flag of the current sequence |
| insn_done | input | 1 | An instruction completed this cycle |
| insn_hold | input | 1 | Hold bit of the completing instruction |
| prev_hold | output | 1 | Hold bit of the last completed instruction |

## Verification
The guard logic is exercised with several read patterns, each of which separates one wrong implementation from the right one:
- A non-fetch read of the guarded program counter must return zero and leave the guard set. This catches a design that lets any read clear the guard.
- A fetch read of the guarded register must return zero and then clear the guard. A later read must return the untouched stored value, which shows the substitution does not destroy storage.
- A read of another register while the guard is set must return real data. This catches a substitution that ignores the address.
- With register 0 as the current program counter, a read must not be substituted.

Further cases cover same-cycle collisions: a sequence change together with a clearing read, start together with a sequence change, and a write together with a read of the same address. Increment and decrement are tried at both wrap points.

// File: rtl/ixrf_pkg.sv
package ixrf_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_INC   = 2'd1,
    OP_DEC   = 2'd2,
    OP_LOADX = 2'd3
  } wr_op_e;
endpackage

// File: rtl/ixrf_store.sv
module ixrf_store #(
  parameter int DATA_W = 18,
  parameter int NREGS  = 64,
  localparam int AW    = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_op,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_raw
);
  import ixrf_pkg::*;

  logic [DATA_W-1:0] regs [NREGS];
  logic [DATA_W-1:0] cur_w;
  logic [DATA_W-1:0] nxt_w;
  wr_op_e            op;

  assign op     = wr_op_e'(wr_op);
  assign cur_w  = regs[wr_addr];
  assign rd_raw = regs[rd_addr];

  // arithmetic on the 18-bit ring: carry out of the top bit is dropped
  always_comb begin
    unique case (op)
      OP_INC:  nxt_w = cur_w + DATA_W'(1);
      OP_DEC:  nxt_w = cur_w - DATA_W'(1);
      default: nxt_w = wr_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[wr_addr] <= nxt_w;
    end
  end
endmodule

// File: rtl/ixrf_rdguard.sv
module ixrf_rdguard #(
  parameter int DATA_W = 18,
  parameter int NREGS  = 64,
  localparam int AW    = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  input  logic              fetch_cycle,
  input  logic [DATA_W-1:0] rd_raw,
  input  logic [AW-1:0]     cur_seq,
  input  logic              cur_valid,
  input  logic              guard,
  output logic              pc_fetch_hit,
  output logic [DATA_W-1:0] rd_data
);
  logic pc_hit;
  logic inhibit;

  assign pc_hit       = rd_en && cur_valid && (rd_addr == cur_seq);
  assign inhibit      = pc_hit && guard && (rd_addr != '0);
  assign pc_fetch_hit = pc_hit && fetch_cycle;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= inhibit ? '0 : rd_raw;
    end
  end
endmodule

// File: rtl/ixrf_seqctl.sv
module ixrf_seqctl #(
  parameter int NSEQ = 64,
  localparam int SW  = $clog2(NSEQ)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          seq_change,
  input  logic [SW-1:0] seq_new,
  input  logic          start,
  input  logic          pc_fetch_hit,
  input  logic          flag_we,
  input  logic [SW-1:0] flag_seq,
  input  logic          flag_val,
  input  logic          insn_done,
  input  logic          insn_hold,
  output logic [SW-1:0] cur_seq,
  output logic          cur_valid,
  output logic          guard,
  output logic          cur_runnable,
  output logic          prev_hold
);
  logic [NSEQ-1:0] runnable;
  logic            do_start;

  assign do_start = start && !cur_valid && !seq_change;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_seq   <= '0;
      cur_valid <= 1'b0;
      guard     <= 1'b0;
    end else begin
      if (seq_change) begin
        cur_seq   <= seq_new;
        cur_valid <= 1'b1;
        guard     <= 1'b1;
      end else if (do_start) begin
        cur_seq   <= '0;
        cur_valid <= 1'b1;
        guard     <= 1'b1;
      end else if (pc_fetch_hit) begin
        guard     <= 1'b0;
      end
    end
  end

  generate
    for (genvar g = 0; g < NSEQ; g++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst)                                   runnable[g] <= 1'b0;
        else if (flag_we && flag_seq == SW'(g))    runnable[g] <= flag_val;
      end
    end
  endgenerate

  assign cur_runnable = cur_valid && runnable[cur_seq];

  always_ff @(posedge clk) begin
    if (rst)            prev_hold <= 1'b0;
    else if (insn_done) prev_hold <= insn_hold;
  end
endmodule

// File: rtl/seq_index_regfile.sv
module seq_index_regfile #(
  parameter int DATA_W = 18,
  parameter int NREGS  = 64,
  localparam int AW    = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  input  logic              fetch_cycle,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [1:0]        wr_op,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              seq_change,
  input  logic [AW-1:0]     seq_new,
  input  logic              start,
  output logic [AW-1:0]     cur_seq,
  output logic              cur_valid,
  output logic              guard,
  input  logic              flag_we,
  input  logic [AW-1:0]     flag_seq,
  input  logic              flag_val,
  output logic              cur_runnable,
  input  logic              insn_done,
  input  logic              insn_hold,
  output logic              prev_hold
);
  logic [DATA_W-1:0] rd_raw;
  logic              pc_fetch_hit;

  ixrf_store #(.DATA_W(DATA_W), .NREGS(NREGS)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_op(wr_op), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_raw(rd_raw)
  );

  ixrf_rdguard #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rdg (
    .clk(clk), .rst(rst),
    .rd_en(rd_en), .rd_addr(rd_addr), .fetch_cycle(fetch_cycle),
    .rd_raw(rd_raw), .cur_seq(cur_seq), .cur_valid(cur_valid),
    .guard(guard), .pc_fetch_hit(pc_fetch_hit), .rd_data(rd_data)
  );

  ixrf_seqctl #(.NSEQ(NREGS)) u_ctl (
    .clk(clk), .rst(rst),
    .seq_change(seq_change), .seq_new(seq_new), .start(start),
    .pc_fetch_hit(pc_fetch_hit),
    .flag_we(flag_we), .flag_seq(flag_seq), .flag_val(flag_val),
    .insn_done(insn_done), .insn_hold(insn_hold),
    .cur_seq(cur_seq), .cur_valid(cur_valid), .guard(guard),
    .cur_runnable(cur_runnable), .prev_hold(prev_hold)
  );
endmodule

// File: rtl/seq_index_regfile_chk.sv
module seq_index_regfile_chk #(
  parameter int DATA_W = 18,
  parameter int AW     = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [AW-1:0]     rd_addr,
  input logic              fetch_cycle,
  input logic [DATA_W-1:0] rd_data,
  input logic              seq_change,
  input logic [AW-1:0]     seq_new,
  input logic              start,
  input logic [AW-1:0]     cur_seq,
  input logic              cur_valid,
  input logic              guard,
  input logic              cur_runnable,
  input logic              insn_done,
  input logic              insn_hold,
  input logic              prev_hold
);
  AST_RD_STABLE: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R2

  AST_START_SEQ0: assert property (@(posedge clk) disable iff (rst)
    (start && !cur_valid && !seq_change) |=> (cur_valid && cur_seq == '0 && guard)); // R5

  AST_SEQ_LOAD: assert property (@(posedge clk) disable iff (rst)
    seq_change |=> (cur_valid && guard && cur_seq == $past(seq_new))); // R6

  AST_GUARDED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cur_valid && guard && rd_addr == cur_seq && rd_addr != '0) |=> (rd_data == '0)); // R7

  AST_GUARD_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (rd_en && fetch_cycle && cur_valid && rd_addr == cur_seq && !seq_change) |=> !guard); // R9

  AST_GUARD_KEEP: assert property (@(posedge clk) disable iff (rst)
    (guard && !(rd_en && fetch_cycle && rd_addr == cur_seq)) |=> guard); // R9

  AST_RUN_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    !cur_valid |-> !cur_runnable); // R11

  AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (rst)
    insn_done |=> (prev_hold == $past(insn_hold))); // R12

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
    !insn_done |=> $stable(prev_hold)); // R12
endmodule

bind seq_index_regfile seq_index_regfile_chk #(.DATA_W(DATA_W), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
  .fetch_cycle(fetch_cycle), .rd_data(rd_data),
  .seq_change(seq_change), .seq_new(seq_new), .start(start),
  .cur_seq(cur_seq), .cur_valid(cur_valid), .guard(guard),
  .cur_runnable(cur_runnable), .insn_done(insn_done),
  .insn_hold(insn_hold), .prev_hold(prev_hold)
);

// File: tb/seq_index_regfile_tb.sv
module seq_index_regfile_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 0, fetch_cycle = 0, wr_en = 0;
  logic [5:0]  rd_addr = 0, wr_addr = 0, seq_new = 0, flag_seq = 0;
  logic [1:0]  wr_op = 0;
  logic [17:0] wr_data = 0;
  logic        seq_change = 0, start = 0, flag_we = 0, flag_val = 0;
  logic        insn_done = 0, insn_hold = 0;
  logic [17:0] rd_data;
  logic [5:0]  cur_seq;
  logic        cur_valid, guard, cur_runnable, prev_hold;

  int n_run = 0;
  int n_fail = 0;

  seq_index_regfile u_dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .fetch_cycle(fetch_cycle), .rd_data(rd_data),
    .wr_en(wr_en), .wr_op(wr_op), .wr_addr(wr_addr), .wr_data(wr_data),
    .seq_change(seq_change), .seq_new(seq_new), .start(start),
    .cur_seq(cur_seq), .cur_valid(cur_valid), .guard(guard),
    .flag_we(flag_we), .flag_seq(flag_seq), .flag_val(flag_val),
    .cur_runnable(cur_runnable), .insn_done(insn_done),
    .insn_hold(insn_hold), .prev_hold(prev_hold)
  );

  always #2 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [1:0] op, input logic [17:0] d);
    wr_en = 1; wr_addr = a; wr_op = op; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic f, output logic [17:0] d);
    rd_en = 1; rd_addr = a; fetch_cycle = f;
    tick();
    d = rd_data;
    rd_en = 0; fetch_cycle = 0;
  endtask

  task automatic chg(input logic [5:0] s);
    seq_change = 1; seq_new = s;
    tick();
    seq_change = 0;
  endtask

  task automatic t_reset();
    logic [17:0] d;
    chk("R1 rd_data", rd_data, 0);
    chk("R1 cur_valid", cur_valid, 0);
    chk("R1 guard", guard, 0);
    chk("R1 cur_runnable", cur_runnable, 0);
    chk("R1 prev_hold", prev_hold, 0);
    rd(6'd9, 1'b0, d);
    chk("R1 register cleared", d, 0);
  endtask

  task automatic t_rw();
    logic [17:0] d;
    wr(6'd5, 2'd0, 18'h12345);
    rd(6'd5, 1'b0, d);
    chk("R3 load", d, 18'h12345);
    tick();
    chk("R2 hold while idle", rd_data, 18'h12345);
    wr(6'd6, 2'd3, 18'h0BEEF);
    // write and read of the same register in one cycle
    wr_en = 1; wr_addr = 6'd6; wr_op = 2'd0; wr_data = 18'h2AAAA;
    rd_en = 1; rd_addr = 6'd6;
    tick();
    wr_en = 0; rd_en = 0;
    chk("R3 read-during-write old", rd_data, 18'h0BEEF);
    rd(6'd6, 1'b0, d);
    chk("R3 new value after", d, 18'h2AAAA);
  endtask

  task automatic t_wrap();
    logic [17:0] d;
    wr(6'd7, 2'd0, 18'h1FFFF);
    wr(6'd7, 2'd1, 18'h0);
    rd(6'd7, 1'b0, d);
    chk("R4 inc into sign", d, 18'h20000);
    wr(6'd8, 2'd2, 18'h0);
    rd(6'd8, 1'b0, d);
    chk("R4 dec wraps", d, 18'h3FFFF);
    wr(6'd8, 2'd1, 18'h0);
    rd(6'd8, 1'b0, d);
    chk("R4 inc wraps", d, 18'h0);
  endtask

  task automatic t_start_reg0();
    logic [17:0] d;
    wr(6'd0, 2'd0, 18'h00ABC);
    start = 1; tick(); start = 0;
    chk("R5 valid", cur_valid, 1);
    chk("R5 seq0", cur_seq, 0);
    chk("R5 guard", guard, 1);
    rd(6'd0, 1'b0, d);
    chk("R8 reg0 not cleared", d, 18'h00ABC);
  endtask

  task automatic t_guard();
    logic [17:0] d;
    wr(6'd33, 2'd0, 18'h00777);
    chg(6'd33);
    chk("R6 seq loaded", cur_seq, 33);
    chk("R6 guard set", guard, 1);
    rd(6'd33, 1'b0, d);
    chk("R7 guarded read zero", d, 0);
    chk("R9 non-fetch keeps guard", guard, 1);
    rd(6'd5, 1'b1, d);
    chk("R7 other reg normal", d, 18'h12345);
    chk("R9 other fetch keeps guard", guard, 1);
    rd(6'd33, 1'b1, d);
    chk("R7 fetch read zero", d, 0);
    chk("R9 fetch clears guard", guard, 0);
    rd(6'd33, 1'b0, d);
    chk("R7 storage intact", d, 18'h00777);
    start = 1; tick(); start = 0;
    chk("R5 start ignored seq", cur_seq, 33);
    chk("R5 start ignored guard", guard, 0);
  endtask

  task automatic t_collide();
    logic [17:0] d;
    chg(6'd34);
    seq_change = 1; seq_new = 6'd35;
    rd_en = 1; rd_addr = 6'd34; fetch_cycle = 1;
    tick();
    seq_change = 0; rd_en = 0; fetch_cycle = 0;
    chk("R10 guard stays", guard, 1);
    chk("R10 new seq", cur_seq, 35);
    chk("R7 collide read zero", rd_data, 0);
    rd(6'd1, 1'b0, d);
  endtask

  task automatic t_flags();
    flag_we = 1; flag_seq = 6'd35; flag_val = 1; tick();
    flag_seq = 6'd36; tick();
    flag_we = 0;
    chk("R11 runnable set", cur_runnable, 1);
    flag_we = 1; flag_seq = 6'd35; flag_val = 0; tick(); flag_we = 0;
    chk("R11 runnable cleared", cur_runnable, 0);
    chg(6'd36);
    chk("R11 follows seq", cur_runnable, 1);
  endtask

  task automatic t_hold();
    insn_hold = 1; tick();
    chk("R12 no done no update", prev_hold, 0);
    insn_done = 1; tick();
    chk("R12 done loads 1", prev_hold, 1);
    insn_hold = 0; insn_done = 0; tick();
    chk("R12 keeps", prev_hold, 1);
    insn_done = 1; tick(); insn_done = 0;
    chk("R12 done loads 0", prev_hold, 0);
  endtask

  task automatic t_prio();
    rst = 1; tick(); rst = 0;
    seq_change = 1; seq_new = 6'd40; start = 1;
    tick();
    seq_change = 0; start = 0;
    chk("R6 priority over start", cur_seq, 40);
    chk("R6 guard after change", guard, 1);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    tick(); tick();
    rst = 0;
    t_reset();
    t_rw();
    t_wrap();
    t_start_reg0();
    t_guard();
    t_collide();
    t_flags();
    t_hold();
    t_prio();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule